// File: doc/BRIEF.md
# Stereo Codec and SRAM Sequencer

This block runs the fixed per-sample transfer schedule of a stereo audio delay line. A pulse on `tick` starts one frame. The sequencer raises a one-cycle left/right alignment strobe and then moves four bytes through a full-duplex mode-0 byte shifter. The outgoing bytes are the processed (delayed) words. The incoming bytes are the dry words from the codec.

While each codec byte is shifting, the block performs one access to a 16-bit asynchronous SRAM in a fixed slot. It reads the delayed left word, writes the new dry left word, reads the delayed right word and writes the new dry right word. The words it reads are sent to the codec in the next frame and are also shown on `dly_l`/`dly_r`. An external address generator supplies a frame read address and a frame write address. The low SRAM address bit selects the channel. At the end of each frame the block returns a single-cycle `adv` pulse so that the generator can step its pointers.

Top module: `stereo_xfer_seq`

## Requirements
- R1: Each frame shifts out, MSB first, the left high byte, left low byte, right high byte and right low byte of the words read from the SRAM in the previous frame. These words are zero after reset.
- R2: The serial link is mode 0. `sclk` idles low and `mosi` changes only while `sclk` is low. `miso` is sampled on the rising edge of `sclk`. Each `sclk` half period lasts DIV clocks.
- R3: `lrclk` is high for exactly one clock per frame, while `sclk` is low and before the first rising `sclk` edge of that frame.
- R4: A read drives `sram_addr` = {rd_addr, ch}, where ch is 0 for left and 1 for right. It holds `sram_ce_n` and `sram_oe_n` low and captures `sram_dq_i` RD_WAIT (2) clocks after the address is driven. `sram_oe_n` is low only during reads.
- R5: A write drives `sram_addr` = {wr_addr, ch} with `sram_ce_n` and `sram_we_n` low. It drives the word for at least one clock before `sram_we_n` rises, and the word is committed on that rising edge. The word is the dry channel word, with the first received byte of that channel in bits 15:8.
- R6: The data bus is released (`sram_dq_oe` = 0) after each write and before any read, and it is never driven while `sram_oe_n` is low.
- R7: SRAM accesses happen in this order, one per slot: left read during byte 1, left write during byte 2, right read during byte 3, right write after byte 3 completes. Bytes are numbered 0 to 3 in shift order.
- R8: Each frame gives exactly 32 `sclk` pulses. After the right write, `adv` pulses for one clock and `dly_l`/`dly_r` show the words read in that frame.
- R9: A `tick` that arrives while a frame is in progress is ignored: it causes no extra frame, strobe or `adv` pulse.
- R10: After reset, `sclk`, `lrclk`, `adv` and `sram_dq_oe` are 0, and `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-period start pulse |
| rd_addr | input | AW | Frame read address from the pointer generator |
| wr_addr | input | AW | Frame write address from the pointer generator |
| adv | output | 1 | One-cycle pulse that steps the pointers |
| dly_l | output | 16 | Delayed left word read this frame |
| dly_r | output | 16 | Delayed right word read this frame |
| sclk | output | 1 | Serial clock to the codec |
| mosi | output | 1 | Serial data to the codec |
| miso | input | 1 | Serial data from the codec |
| lrclk | output | 1 | Left/right alignment strobe |
| sram_addr | output | AW+1 | SRAM word address, with the channel in bit 0 |
| sram_dq_o | output | 16 | SRAM write data |
| sram_dq_i | input | 16 | SRAM read data |
| sram_dq_oe | output | 1 | Data bus output enable |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
A wrong slot in the sequencer shows up at the SRAM pins in the same frame. An access moves to the wrong byte index, or the address carries the wrong channel bit, and the per-frame access log in the bench catches it. A lost or duplicated shifter bit changes the 32-bit word that the bench captures on `mosi`. A wrong captured read or a mixed-up byte lane does not show until one frame later, as a wrong word on `mosi`, and at the end of the frame itself on `dly_l`/`dly_r`. A fault in the bus direction control shows directly as an overlap of `sram_dq_oe` with `sram_oe_n`, or as data that is not driven when `sram_we_n` rises.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LR, SQ_B0, SQ_B1, SQ_B2, SQ_B3, SQ_WR
  } seq_state_t;

  typedef enum logic [2:0] {
    MP_IDLE, MP_RD, MP_W1, MP_W2, MP_W3
  } mem_state_t;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/stx_byte_shift.sv
module stx_byte_shift #(
  parameter int unsigned DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [7:0]    tx_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] div_q;
  logic          active;

  assign mosi = tx_q[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_byte <= '0;
      bit_q   <= '0;
      div_q   <= '0;
      active  <= 1'b0;
      done    <= 1'b1;
      sclk    <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_byte;
      bit_q  <= '0;
      div_q  <= '0;
      active <= 1'b1;
      done   <= 1'b0;
      sclk   <= 1'b0;
    end else if (active) begin
      if (div_q == CW'(DIV - 1)) begin
        div_q <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_q == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> !done);
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
endmodule

// File: rtl/stx_sram_port.sv
module stx_sram_port
  import stx_pkg::*;
#(
  parameter int unsigned SAW     = 11,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wr,
  input  logic [SAW-1:0]    addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              busy,
  output logic [SAW-1:0]    sram_addr,
  output logic [WORD_W-1:0] sram_dq_o,
  input  logic [WORD_W-1:0] sram_dq_i,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  localparam int unsigned WW = $clog2(RD_WAIT + 1);

  mem_state_t    st;
  logic [WW-1:0] wait_q;

  assign busy = (st != MP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= MP_IDLE;
      wait_q     <= '0;
      rdata      <= '0;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
    end else begin
      case (st)
        MP_IDLE: if (go) begin
          sram_addr <= addr;
          sram_ce_n <= 1'b0;
          wait_q    <= '0;
          if (wr) begin
            sram_we_n <= 1'b0;
            sram_dq_o <= wdata;
            st        <= MP_W1;
          end else begin
            sram_oe_n <= 1'b0;
            st        <= MP_RD;
          end
        end
        MP_RD: begin
          if (wait_q == WW'(RD_WAIT - 1)) begin
            rdata     <= sram_dq_i;
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            st        <= MP_IDLE;
          end else begin
            wait_q <= wait_q + WW'(1);
          end
        end
        MP_W1: begin
          sram_dq_oe <= 1'b1;
          st         <= MP_W2;
        end
        MP_W2: begin
          sram_we_n <= 1'b1;
          st        <= MP_W3;
        end
        MP_W3: begin
          sram_dq_oe <= 1'b0;
          sram_ce_n  <= 1'b1;
          st         <= MP_IDLE;
        end
        default: st <= MP_IDLE;
      endcase
    end
  end

  p_no_bus_fight_r6: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));
  p_we_rise_data_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_dq_oe && $past(sram_dq_oe)));
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
endmodule

// File: rtl/stereo_xfer_seq.sv
module stereo_xfer_seq
  import stx_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned DIV     = 2,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  output logic          adv,
  output logic [15:0]   dly_l,
  output logic [15:0]   dly_r,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          lrclk,
  output logic [AW:0]   sram_addr,
  output logic [15:0]   sram_dq_o,
  input  logic [15:0]   sram_dq_i,
  output logic          sram_dq_oe,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  localparam int unsigned SAW = AW + 1;

  seq_state_t        st;
  logic              sh_load, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  logic              m_go, m_wr, m_busy;
  logic [SAW-1:0]    m_addr;
  logic [WORD_W-1:0] m_wdata, m_rdata;
  logic [15:0]       wet_l, wet_r, nxt_l, nxt_r;
  logic [7:0]        hi_byte;
  logic              ready;

  assign ready = sh_done && !sh_load && !m_busy && !m_go;
  assign dly_l = wet_l;
  assign dly_r = wet_r;

  stx_byte_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .tx_byte(sh_tx),
    .rx_byte(sh_rx), .done(sh_done), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  stx_sram_port #(.SAW(SAW), .RD_WAIT(RD_WAIT)) u_port (
    .clk(clk), .rst(rst), .go(m_go), .wr(m_wr), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata), .busy(m_busy),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      sh_load <= 1'b0;
      sh_tx   <= '0;
      m_go    <= 1'b0;
      m_wr    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
      wet_l   <= '0;
      wet_r   <= '0;
      nxt_l   <= '0;
      nxt_r   <= '0;
      hi_byte <= '0;
      adv     <= 1'b0;
      lrclk   <= 1'b0;
    end else begin
      sh_load <= 1'b0;
      m_go    <= 1'b0;
      adv     <= 1'b0;
      lrclk   <= 1'b0;
      case (st)
        SQ_IDLE: if (tick) begin
          lrclk <= 1'b1;
          st    <= SQ_LR;
        end
        SQ_LR: begin
          sh_load <= 1'b1;
          sh_tx   <= wet_l[15:8];
          st      <= SQ_B0;
        end
        SQ_B0: if (ready) begin
          hi_byte <= sh_rx;
          sh_load <= 1'b1;
          sh_tx   <= wet_l[7:0];
          m_go    <= 1'b1;
          m_wr    <= 1'b0;
          m_addr  <= {rd_addr, 1'b0};
          st      <= SQ_B1;
        end
        SQ_B1: if (ready) begin
          nxt_l   <= m_rdata;
          sh_load <= 1'b1;
          sh_tx   <= wet_r[15:8];
          m_go    <= 1'b1;
          m_wr    <= 1'b1;
          m_addr  <= {wr_addr, 1'b0};
          m_wdata <= {hi_byte, sh_rx};
          st      <= SQ_B2;
        end
        SQ_B2: if (ready) begin
          hi_byte <= sh_rx;
          sh_load <= 1'b1;
          sh_tx   <= wet_r[7:0];
          m_go    <= 1'b1;
          m_wr    <= 1'b0;
          m_addr  <= {rd_addr, 1'b1};
          st      <= SQ_B3;
        end
        SQ_B3: if (ready) begin
          nxt_r   <= m_rdata;
          m_go    <= 1'b1;
          m_wr    <= 1'b1;
          m_addr  <= {wr_addr, 1'b1};
          m_wdata <= {hi_byte, sh_rx};
          st      <= SQ_WR;
        end
        SQ_WR: if (!m_busy && !m_go) begin
          wet_l <= nxt_l;
          wet_r <= nxt_r;
          adv   <= 1'b1;
          st    <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  p_lr_single_r3: assert property (@(posedge clk) disable iff (rst)
    lrclk |=> !lrclk);
  p_lr_sclk_low_r3: assert property (@(posedge clk) disable iff (rst)
    lrclk |-> !sclk);
  p_adv_single_r8: assert property (@(posedge clk) disable iff (rst)
    adv |=> !adv);
  p_adv_bus_free_r6: assert property (@(posedge clk) disable iff (rst)
    adv |-> (!sram_dq_oe && sram_ce_n));
endmodule

// File: tb/stereo_xfer_seq_bench.sv
module stereo_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int DIV = 2;
  localparam int NW  = 2 ** (AW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic          adv, sclk, mosi, lrclk, sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic          miso = 1'b0;
  logic [15:0]   dly_l, dly_r, sram_dq_o, sram_dq_i;
  logic [AW:0]   sram_addr;

  logic [15:0] mem [NW];
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_xfer_seq #(.AW(AW), .DIV(DIV), .RD_WAIT(2)) u_stereo_xfer_seq (
    .clk(clk), .rst(rst), .tick(tick), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .adv(adv), .dly_l(dly_l), .dly_r(dly_r), .sclk(sclk), .mosi(mosi),
    .miso(miso), .lrclk(lrclk), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_i(sram_dq_i), .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [31:0] dry_word = '0, mosi_word = '0;
  int   rises = 0, miso_idx = 0, adv_cnt = 0, lr_cnt = 0, lr_bad = 0;
  int   mode_bad = 0, fight_bad = 0, we_bad = 0, ev_n = 0;
  int   ev_byte [4];
  bit   ev_wr [4];
  logic [AW:0] ev_addr [4];
  logic p_sclk = 0, p_mosi = 0, p_ce = 1, p_we = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (lrclk) begin
        lr_cnt++;
        if (sclk || rises != 0) lr_bad++;
        miso_idx = 0;
        miso = dry_word[31];
      end
      if (sclk && mosi != p_mosi) mode_bad++;
      if (sclk && !p_sclk) begin
        mosi_word = {mosi_word[30:0], mosi};
        rises++;
      end
      if (!sclk && p_sclk) begin
        miso_idx++;
        if (miso_idx < 32) miso = dry_word[31 - miso_idx];
      end
      if (sram_dq_oe && !sram_oe_n) fight_bad++;
      if (!sram_ce_n && p_ce && ev_n < 4) begin
        ev_byte[ev_n] = rises / 8;
        ev_wr[ev_n]   = !sram_we_n;
        ev_addr[ev_n] = sram_addr;
        ev_n++;
      end
      if (sram_we_n && !p_we) begin
        if (!sram_dq_oe || sram_ce_n) we_bad++;
        mem[sram_addr] = sram_dq_o;
      end
      if (adv) adv_cnt++;
    end
    p_sclk = sclk; p_mosi = mosi; p_ce = sram_ce_n; p_we = sram_we_n;
  end

  logic [15:0] prev_l = '0, prev_r = '0;
  bit hung = 0;

  task automatic run_frame(input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                           input logic [31:0] dw, input bit extra_tick);
    logic [15:0] exp_l, exp_r;
    int a0, n;
    rd_addr = ra; wr_addr = wa; dry_word = dw;
    exp_l = mem[{ra, 1'b0}];
    exp_r = mem[{ra, 1'b1}];
    rises = 0; ev_n = 0; lr_cnt = 0; lr_bad = 0; mode_bad = 0; fight_bad = 0; we_bad = 0;
    a0 = adv_cnt;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    n = 0;
    while (adv_cnt == a0 && n < 5000) begin
      @(negedge clk); n++;
      if (extra_tick && n == 40) tick = 1'b1;
      else tick = 1'b0;
    end
    if (n >= 5000) begin hung = 1; chk(0, "R8 frame hung", n, 0); return; end
    // dly outputs valid at adv, already updated
    chk(dly_l == exp_l, "R8 dly_l", dly_l, exp_l);
    chk(dly_r == exp_r, "R8 dly_r", dly_r, exp_r);
    chk(mosi_word == {prev_l, prev_r}, "R1 mosi word", mosi_word, {prev_l, prev_r});
    chk(rises == 32, "R8 sclk pulses", rises, 32);
    chk(lr_cnt == 1 && lr_bad == 0, "R3 lrclk strobe", lr_cnt, 1);
    chk(mode_bad == 0, "R2 mosi moved while sclk high", mode_bad, 0);
    chk(fight_bad == 0 && !sram_dq_oe, "R6 bus release", fight_bad, 0);
    chk(we_bad == 0, "R5 data driven at we rise", we_bad, 0);
    chk(ev_n == 4, "R7 access count", ev_n, 4);
    chk(ev_byte[0] == 1 && !ev_wr[0] && ev_addr[0] == {ra, 1'b0}, "R7 R4 left read",
        {ev_byte[0], ev_addr[0]}, {1, ra, 1'b0});
    chk(ev_byte[1] == 2 && ev_wr[1] && ev_addr[1] == {wa, 1'b0}, "R7 R5 left write",
        {ev_byte[1], ev_addr[1]}, {2, wa, 1'b0});
    chk(ev_byte[2] == 3 && !ev_wr[2] && ev_addr[2] == {ra, 1'b1}, "R7 R4 right read",
        {ev_byte[2], ev_addr[2]}, {3, ra, 1'b1});
    chk(ev_byte[3] == 4 && ev_wr[3] && ev_addr[3] == {wa, 1'b1}, "R7 R5 right write",
        {ev_byte[3], ev_addr[3]}, {4, wa, 1'b1});
    chk(mem[{wa, 1'b0}] == dw[31:16], "R5 left word stored", mem[{wa, 1'b0}], dw[31:16]);
    chk(mem[{wa, 1'b1}] == dw[15:0], "R5 right word stored", mem[{wa, 1'b1}], dw[15:0]);
    repeat (300) @(negedge clk);
    chk(adv_cnt == a0 + 1, "R9 single adv per frame", adv_cnt - a0, 1);
    chk(lr_cnt == 1 && rises == 32, "R9 no extra frame", lr_cnt, 1);
    prev_l = exp_l; prev_r = exp_r;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 16'hA000 + 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    chk(!sclk && !lrclk && !adv && !sram_dq_oe, "R10 reset low outputs",
        {sclk, lrclk, adv, sram_dq_oe}, 0);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R10 reset strobes high",
        {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int f = 0; f < 12 && !hung; f++) begin
      logic [AW-1:0] ra, wa;
      ra = AW'(f * 3);
      wa = AW'(f * 5 + 1);
      if (f == 4) wa = ra;
      if (f == 6) begin ra = '1; wa = '1; end
      if (f == 7) begin ra = '0; wa = '1; end
      run_frame(ra, wa, {16'(16'h1357 * (f + 1)), 16'(16'hC0DE ^ (f * 16'h0F1))}, f[0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule